// File: doc/BRIEF.md
# GPIO Controller with Level and Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. The number of pins is set by a parameter. For each pin, software sets an output value and an output enable, and it reads back the pin state after a two-flop synchronizer.

Each pin can raise two kinds of interrupt:

- **Level interrupt.** It is pending while the synchronized pin differs from a per-pin polarity bit, provided the pin's level mask allows it. It is computed combinationally and is never latched.
- **Edge interrupt.** A rising or falling transition, chosen per pin, sets a sticky event flag. Software clears the flag by writing 1 to its bit.

Every pending condition of either kind is ORed into a single aggregate bit of a top-level status register. A top-level mask bit gates that aggregate bit onto the one interrupt output.

The register port is a simple single-cycle bus:

- **Writes** take effect at the clock edge on which `bus_sel` and `bus_we` are both high.
- **Read data** is combinational from `bus_addr` while `bus_sel` is high and `bus_we` is low. Otherwise it is zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: Pin p drives `pin_out[p]` = output-value bit p only while output-enable bit p is 1. While that enable bit is 0, `pin_out[p]` is 0 and the written output value is kept. The output value register is at byte offset 0x44 and the output enable register is at 0x48.
- R3: The input register at 0x40 shows `pin_in` exactly two clock edges after it changes, and not after one.
- R4: Pin p has a level interrupt pending when (synchronized input XOR level polarity) AND level mask is 1 for bit p. A polarity bit of 1 makes the pin active-low. Level polarity is at 0x50 and level mask is at 0x54.
- R5: The edge polarity register is at 0x64. A 0 in bit p selects rising edges of pin p and a 1 selects falling edges. A selected edge sets event bit p at 0x58 whatever the event mask at 0x5C holds. An edge of the other direction leaves the event bit unchanged.
- R6: Writing 1 to a bit at 0x58 clears that event bit. Writing 0 leaves it unchanged. A selected edge that lands on the same clock edge as the clear leaves the bit set.
- R7: Status bit 0 at 0x00 reads 1 when any pin has a level interrupt pending, or a set event bit whose event mask bit is 1. `irq` equals that bit ANDed with top mask bit 0 at 0x04. Writes to 0x00 are ignored.
- R8: Reads of unmapped offsets return 0, and writes to them change no register. Register bits at and above `N_PINS`, and bits 31..1 of the two top-level registers, read 0.
- R9: Each writable register reads back, at its own offset, the value last written to it. The writable registers are the ones at 0x04, 0x44, 0x48, 0x50, 0x54, 0x5C and 0x64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | N_PINS | Asynchronous pin inputs |
| pin_out | output | N_PINS | Pin output values, gated by enable |
| pin_oe | output | N_PINS | Pin output enables |
| irq | output | 1 | Aggregate interrupt request |

## Verification
The synchronizer check assumes that `pin_in` is a plain two-valued signal sampled at the rising edge. The bench therefore changes pins only on falling edges, and it holds them low through reset so that no spurious rising edge is latched when reset is released.

The event checks assume that a clear mask reaches the latch only during a write to the event offset. The bench always drops `bus_sel` one cycle after each access, so every write commits at exactly one known edge.

The same-edge race is created deliberately by timing a clear write to commit on the third edge after a pin change. That is the edge on which the synchronized edge sets the flag.

// File: rtl/gpio_irq_pkg.sv
// Package: shared bus constants, register offsets and the address decoder
// for the GPIO interrupt controller. Assumes byte addressing with
// word-aligned registers.
package gpio_irq_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFF_TOP_STAT = 7'h00;
    localparam logic [ADDR_W-1:0] OFF_TOP_MASK = 7'h04;
    localparam logic [ADDR_W-1:0] OFF_DIN      = 7'h40;
    localparam logic [ADDR_W-1:0] OFF_DOUT     = 7'h44;
    localparam logic [ADDR_W-1:0] OFF_OE       = 7'h48;
    localparam logic [ADDR_W-1:0] OFF_LVL_POL  = 7'h50;
    localparam logic [ADDR_W-1:0] OFF_LVL_MASK = 7'h54;
    localparam logic [ADDR_W-1:0] OFF_EVT      = 7'h58;
    localparam logic [ADDR_W-1:0] OFF_EVT_MASK = 7'h5C;
    localparam logic [ADDR_W-1:0] OFF_EVT_POL  = 7'h64;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TOP_STAT,
        SEL_TOP_MASK,
        SEL_DIN,
        SEL_DOUT,
        SEL_OE,
        SEL_LVL_POL,
        SEL_LVL_MASK,
        SEL_EVT,
        SEL_EVT_MASK,
        SEL_EVT_POL
    } reg_sel_e;

    // Map a byte offset onto a register selector; unmapped offsets give SEL_NONE.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_TOP_STAT: s = SEL_TOP_STAT;
            OFF_TOP_MASK: s = SEL_TOP_MASK;
            OFF_DIN:      s = SEL_DIN;
            OFF_DOUT:     s = SEL_DOUT;
            OFF_OE:       s = SEL_OE;
            OFF_LVL_POL:  s = SEL_LVL_POL;
            OFF_LVL_MASK: s = SEL_LVL_MASK;
            OFF_EVT:      s = SEL_EVT;
            OFF_EVT_MASK: s = SEL_EVT_MASK;
            OFF_EVT_POL:  s = SEL_EVT_POL;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for the GPIO pin inputs.
// Assumes: pin_in is asynchronous to clk; each bit is synchronized on its own,
// so bits of a multi-bit change may appear one cycle apart.
module gpio_in_sync #(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] sync_q
);

    localparam int STAGES = 2;

    logic [STAGES-1:0][N_PINS-1:0] chain_q;

    // Shift every pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= pin_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_q = chain_q[STAGES-1];

    // Checker only: counts the cycles since reset, so the delay check
    // never looks back past reset.
    logic [1:0] warm_cnt;

    // Saturating count of cycles since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n)                warm_cnt <= '0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end

    // R3: the synchronized value is the pin value from two edges earlier.
    p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt == 2'd2) |-> (sync_q == $past(pin_in, 2)));

endmodule

// File: rtl/gpio_edge_event.sv
// Module: per-pin edge detector and sticky, write-1-to-clear event latch.
// Assumes: sync_q is already synchronized to clk; clr_mask is non-zero only
// in the cycle in which a write to the event register commits.
module gpio_edge_event #(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] sync_q,
    input  logic [N_PINS-1:0] edge_pol,
    input  logic [N_PINS-1:0] clr_mask,
    output logic [N_PINS-1:0] ev_q
);

    logic [N_PINS-1:0] prev_q;
    logic [N_PINS-1:0] hit;

    // Remember the previous synchronized value so transitions can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q;
    end

    // Per pin, choose the rising or falling transition as the event source.
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        always_comb begin
            if (edge_pol[p]) hit[p] = prev_q[p] & ~sync_q[p];
            else             hit[p] = ~prev_q[p] & sync_q[p];
        end
    end

    // Latch events: a clear drops bits, and a new hit always wins.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~clr_mask) | hit;
    end

    // R5: a detected edge is always reflected in the event flag next cycle.
    p_event_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit) & ~ev_q) == '0));

    // R6: a set flag stays set unless a clear hit its bit.
    p_event_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(ev_q) & ~$past(clr_mask)) & ~ev_q) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top level of the GPIO controller. Holds the register file, the
// read mux and the interrupt merge.
// Assumes: N_PINS <= 32; the bus presents one access per cycle; reads are
// combinational and writes commit at the rising edge.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);

    reg_sel_e          sel;
    logic              wr_en;
    logic              rd_en;
    logic [N_PINS-1:0] wdata_n;

    logic [N_PINS-1:0] dout_q;
    logic [N_PINS-1:0] oe_q;
    logic [N_PINS-1:0] lvl_pol_q;
    logic [N_PINS-1:0] lvl_mask_q;
    logic [N_PINS-1:0] evt_mask_q;
    logic [N_PINS-1:0] evt_pol_q;
    logic              top_mask_q;

    logic [N_PINS-1:0] din_sync;
    logic [N_PINS-1:0] evt_q;
    logic [N_PINS-1:0] clr_mask;
    logic [N_PINS-1:0] level_pend;
    logic [N_PINS-1:0] edge_pend;
    logic              any_pend;

    assign sel     = decode_addr(bus_addr);
    assign wr_en   = bus_sel & bus_we;
    assign rd_en   = bus_sel & ~bus_we;
    assign wdata_n = bus_wdata[N_PINS-1:0];

    gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_q (din_sync)
    );

    // A clear mask is passed on only while a write to the event register commits.
    assign clr_mask = (wr_en && sel == SEL_EVT) ? wdata_n : '0;

    gpio_edge_event #(.N_PINS(N_PINS)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_q   (din_sync),
        .edge_pol (evt_pol_q),
        .clr_mask (clr_mask),
        .ev_q     (evt_q)
    );

    // Update the writable configuration registers from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q     <= '0;
            oe_q       <= '0;
            lvl_pol_q  <= '0;
            lvl_mask_q <= '0;
            evt_mask_q <= '0;
            evt_pol_q  <= '0;
            top_mask_q <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_TOP_MASK: top_mask_q <= bus_wdata[0];
                SEL_DOUT:     dout_q     <= wdata_n;
                SEL_OE:       oe_q       <= wdata_n;
                SEL_LVL_POL:  lvl_pol_q  <= wdata_n;
                SEL_LVL_MASK: lvl_mask_q <= wdata_n;
                SEL_EVT_MASK: evt_mask_q <= wdata_n;
                SEL_EVT_POL:  evt_pol_q  <= wdata_n;
                default:      ;
            endcase
        end
    end

    // Drive the pads: the output value appears only where it is enabled.
    assign pin_oe  = oe_q;
    assign pin_out = dout_q & oe_q;

    // Merge the level and masked edge conditions into the aggregate request.
    assign level_pend = (din_sync ^ lvl_pol_q) & lvl_mask_q;
    assign edge_pend  = evt_q & evt_mask_q;
    assign any_pend   = |(level_pend | edge_pend);
    assign irq        = any_pend & top_mask_q;

    // Read mux: return zero-extended register contents; unmapped offsets read 0.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_TOP_STAT: bus_rdata[0]        = any_pend;
                SEL_TOP_MASK: bus_rdata[0]        = top_mask_q;
                SEL_DIN:      bus_rdata[N_PINS-1:0] = din_sync;
                SEL_DOUT:     bus_rdata[N_PINS-1:0] = dout_q;
                SEL_OE:       bus_rdata[N_PINS-1:0] = oe_q;
                SEL_LVL_POL:  bus_rdata[N_PINS-1:0] = lvl_pol_q;
                SEL_LVL_MASK: bus_rdata[N_PINS-1:0] = lvl_mask_q;
                SEL_EVT:      bus_rdata[N_PINS-1:0] = evt_q;
                SEL_EVT_MASK: bus_rdata[N_PINS-1:0] = evt_mask_q;
                SEL_EVT_POL:  bus_rdata[N_PINS-1:0] = evt_pol_q;
                default:      bus_rdata = '0;
            endcase
        end
    end

    // R2: the output value holds unless a write to its own offset commits.
    p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == OFF_DOUT) |=> $stable(dout_q));

    // R8: a write to an unmapped offset leaves the configuration untouched.
    p_unmapped_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=>
            ($stable(oe_q) && $stable(lvl_mask_q) && $stable(evt_mask_q) && $stable(top_mask_q)));

    // R7: with the top mask clear, no interrupt leaves the block.
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !top_mask_q |-> !irq);

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.N_PINS(NP)) u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        logic [6:0] offs [10] = '{7'h00, 7'h04, 7'h40, 7'h44, 7'h48, 7'h50, 7'h54, 7'h58, 7'h5C, 7'h64};
        foreach (offs[i]) begin
            rd(offs[i], d);
            chk("R1 register reset", d, 32'h0);
        end
        chk("R1 pin_oe reset", 32'(pin_oe), 32'h0);
        chk("R1 pin_out reset", 32'(pin_out), 32'h0);
        chk("R1 irq reset", 32'(irq), 32'h0);
    endtask

    task automatic t_output;
        logic [31:0] d;
        wr(7'h44, 32'h0000_00A5);
        @(negedge clk);
        chk("R2 pin_out gated while disabled", 32'(pin_out), 32'h0);
        rd(7'h44, d);
        chk("R2 output value retained", d, 32'h0000_00A5);
        wr(7'h48, 32'h0000_000F);
        @(negedge clk);
        chk("R2 pin_out enabled bits", 32'(pin_out), 32'h0000_0005);
        chk("R2 pin_oe follows enable", 32'(pin_oe), 32'h0000_000F);
    endtask

    task automatic t_sync;
        logic [31:0] d;
        @(negedge clk);
        pin_in = 16'h1234;
        @(posedge clk);
        rd(7'h40, d);
        chk("R3 input not visible after one edge", d, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 7'h40;
        #0.5 d = bus_rdata;
        bus_sel = 1'b0;
        chk("R3 input visible after two edges", d, 32'h0000_1234);
        set_pins('0);
        wr(7'h58, 32'hFFFF_FFFF);
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(7'h04, 32'h1);
        wr(7'h54, 32'h0001);
        @(negedge clk);
        chk("R4 no level pending with pin low", 32'(irq), 32'h0);
        set_pins(16'h0001);
        chk("R4 active-high level raises irq", 32'(irq), 32'h1);
        rd(7'h00, d);
        chk("R7 status shows level pending", d, 32'h1);
        wr(7'h50, 32'h0001);
        @(negedge clk);
        chk("R4 active-low polarity with pin high", 32'(irq), 32'h0);
        set_pins(16'h0000);
        chk("R4 active-low polarity with pin low", 32'(irq), 32'h1);
        wr(7'h04, 32'h0);
        @(negedge clk);
        chk("R7 top mask blocks irq", 32'(irq), 32'h0);
        rd(7'h00, d);
        chk("R7 status still set under top mask", d, 32'h1);
        wr(7'h00, 32'h0);
        rd(7'h00, d);
        chk("R7 status is read-only", d, 32'h1);
        wr(7'h54, 32'h0);
        wr(7'h50, 32'h0);
        wr(7'h04, 32'h1);
        wr(7'h58, 32'hFFFF_FFFF);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        wr(7'h64, 32'h0002);
        set_pins(16'h0001);
        set_pins(16'h0003);
        rd(7'h58, d);
        chk("R5 rising edge latched, falling-sense pin ignores rise", d, 32'h0001);
        set_pins(16'h0001);
        rd(7'h58, d);
        chk("R5 falling edge latched despite event mask 0", d, 32'h0003);
        chk("R7 unmasked events keep irq low", 32'(irq), 32'h0);
        rd(7'h00, d);
        chk("R7 status ignores masked events", d, 32'h0);
        wr(7'h5C, 32'h0001);
        @(negedge clk);
        chk("R7 masked-in event raises irq", 32'(irq), 32'h1);
        wr(7'h58, 32'h0002);
        rd(7'h58, d);
        chk("R6 write one clears only its bit", d, 32'h0001);
        wr(7'h58, 32'h0);
        rd(7'h58, d);
        chk("R6 write zero leaves events", d, 32'h0001);
        wr(7'h58, 32'h0001);
        @(negedge clk);
        chk("R6 clear drops irq", 32'(irq), 32'h0);
        set_pins(16'h0000);
        rd(7'h58, d);
        chk("R5 falling edge on rising-sense pin ignored", d, 32'h0);
        wr(7'h5C, 32'h0);
        wr(7'h64, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] d;
        set_pins(16'h0004);
        set_pins(16'h0000);
        rd(7'h58, d);
        chk("R5 event for pin 2 set", d, 32'h0004);
        @(negedge clk);
        pin_in = 16'h0004;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 7'h58; bus_wdata = 32'h0004;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(7'h58, d);
        chk("R6 edge on clear cycle keeps bit set", d, 32'h0004);
        wr(7'h58, 32'h0004);
        rd(7'h58, d);
        chk("R6 plain clear afterwards", d, 32'h0);
        set_pins(16'h0000);
        wr(7'h58, 32'hFFFF_FFFF);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(7'h50, 32'h0000_1111);
        wr(7'h54, 32'h0000_2222);
        wr(7'h5C, 32'h0000_3333);
        wr(7'h64, 32'h0000_4444);
        rd(7'h50, d); chk("R9 level polarity readback", d, 32'h0000_1111);
        rd(7'h54, d); chk("R9 level mask readback", d, 32'h0000_2222);
        rd(7'h5C, d); chk("R9 event mask readback", d, 32'h0000_3333);
        rd(7'h64, d); chk("R9 edge polarity readback", d, 32'h0000_4444);
        rd(7'h04, d); chk("R9 top mask readback", d, 32'h1);
        wr(7'h44, 32'hFFFF_FFFF);
        rd(7'h44, d);
        chk("R8 bits above pin count read zero", d, 32'h0000_FFFF);
        wr(7'h04, 32'hFFFF_FFFF);
        rd(7'h04, d);
        chk("R8 top mask upper bits read zero", d, 32'h1);
        wr(7'h4C, 32'hDEAD_BEEF);
        rd(7'h4C, d);
        chk("R8 unmapped read zero", d, 32'h0);
        rd(7'h48, d);
        chk("R8 unmapped write left enable", d, 32'h0000_000F);
        rd(7'h44, d);
        chk("R8 unmapped write left output value", d, 32'h0000_FFFF);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_output();
        t_sync();
        t_level();
        t_edge();
        t_race();
        t_map();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule